// File: doc/BRIEF.md
# Remembered-Matching Weight Learner

This block picks a crossbar configuration for an N-by-N input-queued switch once per scheduling slot. It does not solve a full maximum-weight matching. It remembers the matching it chose in the previous slot, stored as a permutation that gives the output for each input. Each slot it sets a small set of cheap alternatives against that stored matching and keeps the heaviest. The alternatives are a set of adjacent two-edge swaps of the stored matching and one pseudo-random permutation. The weight of a matching is the sum of the queue lengths on its edges.

A slot starts when the slot strobe is high while the block is idle. On that edge the block captures the queue-length matrix and the random candidate. On the next edge it evaluates every candidate in parallel, registers the winner with its weight, and raises a one-cycle valid pulse. Because the stored matching is always one of the candidates, the chosen weight never drops below the stored matching's weight on the same queue state.

Top module: `mwl_match_learner`

## Requirements
- R1: After reset, match_o is the identity permutation (input i to output i), weight_o is 0 and valid_o is low.
- R2: A slot strobe sampled high while idle is accepted on that clock edge. valid_o is high for exactly one cycle, after the second rising edge counted from the accepting edge.
- R3: qlen_i holds entry (input i, output j) at bits (i*N+j)*WBITS, WBITS wide. match_o holds the output index of input i at bits i*IDXW. When valid_o is high, weight_o equals the sum over i of the captured entry (i, match_o[i]).
- R4: match_o is always a permutation: every output index appears exactly once.
- R5: The selected weight is never below the weight of the previously stored matching, evaluated on the captured queue lengths.
- R6: The selected weight is at least the weight of every neighbour. Neighbour k (k = 0 .. NNB-1) is the stored matching with the outputs of inputs k and (k+1) mod N exchanged.
- R7: A candidate replaces another only when it is strictly heavier. The order of preference is the stored matching, then the neighbours in ascending k, then the random candidate. On a tie the earlier one is kept.
- R8: The random candidate is a valid permutation built from LFSR-chosen transpositions of the identity. The LFSR advances on each accepted slot, and the candidate wins whenever it is strictly heavier than all the others.
- R9: Changes on qlen_i after the accepting edge do not affect that slot's result. A strobe that arrives during evaluation is ignored and produces no second valid pulse.
- R10: match_o and weight_o hold their values in every cycle in which valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_i | input | 1 | Slot strobe, starts one selection |
| qlen_i | input | N*N*WBITS | Queue-length matrix, row-major by input |
| match_o | output | N*IDXW | Selected permutation, output index per input |
| weight_o | output | WBITS+clog2(N) | Weight of the selected permutation |
| valid_o | output | 1 | One-cycle pulse when a new selection is registered |

## Verification
A corrupted stored matching appears at the ports within the same slot. It shows up as a repeated output index in match_o, or as a weight_o that disagrees with the queue-length sum of the reported permutation. A wrong tie rule, or a wrong neighbour pair, shows in the first slot whose matrix makes the preferred neighbour strictly best or makes all candidates equal. The bench predicts the exact winner whenever the random candidate does not strictly win. A capture or strobe-handling fault shifts or duplicates the valid pulse, which is seen one or two cycles after the strobe.

// File: rtl/mwl_pkg.sv
package mwl_pkg;
  typedef enum logic {ST_IDLE, ST_EVAL} mwl_state_e;
  localparam int LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;
endpackage

// File: rtl/mwl_rand_perm.sv
module mwl_rand_perm #(
  parameter int N = 4,
  parameter int IDXW = 2,
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_i,
  output logic [N*IDXW-1:0] perm_o
);
  import mwl_pkg::*;
  localparam logic [LFSR_W-1:0] PICK_MASK = LFSR_W'((1 << (IDXW + 1)) - 1);

  logic [LFSR_W-1:0] lfsr_q, lfsr_d;
  logic [IDXW-1:0]   p [N];

  // next state of the Galois shift register
  always_comb begin
    lfsr_d = lfsr_q;
    if (adv_i) begin
      lfsr_d = (lfsr_q >> 1) ^ (lfsr_q[0] ? LFSR_TAPS : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q <= SEED;
    end else begin
      lfsr_q <= lfsr_d;
    end
  end

  // identity shuffled by descending transpositions
  always_comb begin
    logic [IDXW-1:0]   tmp;
    logic [LFSR_W-1:0] rot;
    int                sh;
    int                j;
    for (int i = 0; i < N; i++) begin
      p[i] = IDXW'(i);
    end
    for (int s = N - 1; s >= 1; s--) begin
      sh     = (s * 5) % LFSR_W;
      rot    = (lfsr_q >> sh) | (lfsr_q << (LFSR_W - sh));
      j      = int'(rot & PICK_MASK) % (s + 1);
      tmp    = p[s];
      p[s]   = p[j];
      p[j]   = tmp;
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      perm_o[i*IDXW +: IDXW] = p[i];
    end
  end

  // R8: the random candidate is always a permutation
  logic [N-1:0] rp_seen;
  always_comb begin
    rp_seen = '0;
    for (int i = 0; i < N; i++) begin
      rp_seen[perm_o[i*IDXW +: IDXW]] = 1'b1;
    end
  end

  a_r8_rand_is_perm: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rp_seen) == N);
  a_r8_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);
endmodule

// File: rtl/mwl_weight.sv
module mwl_weight #(
  parameter int N = 4,
  parameter int IDXW = 2,
  parameter int WBITS = 4,
  parameter int SUMW = 6
) (
  input  logic [N*IDXW-1:0]    perm_i,
  input  logic [N*N*WBITS-1:0] qlen_i,
  output logic [SUMW-1:0]      weight_o
);
  always_comb begin
    logic [SUMW-1:0] acc;
    int              col;
    acc = '0;
    for (int i = 0; i < N; i++) begin
      col = int'(perm_i[i*IDXW +: IDXW]);
      acc = acc + SUMW'(qlen_i[(i*N + col)*WBITS +: WBITS]);
    end
    weight_o = acc;
  end
endmodule

// File: rtl/mwl_match_learner.sv
module mwl_match_learner #(
  parameter int N = 4,
  parameter int WBITS = 4,
  parameter int NNB = N - 1,
  parameter logic [15:0] SEED = 16'hACE1,
  localparam int IDXW = (N > 1) ? $clog2(N) : 1,
  localparam int SUMW = WBITS + $clog2(N)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 slot_i,
  input  logic [N*N*WBITS-1:0] qlen_i,
  output logic [N*IDXW-1:0]    match_o,
  output logic [SUMW-1:0]      weight_o,
  output logic                 valid_o
);
  import mwl_pkg::*;

  localparam int NC  = NNB + 2;
  localparam int CIW = $clog2(NC);

  mwl_state_e           state_q, state_d;
  logic [N*N*WBITS-1:0] qlen_q, qlen_d;
  logic [N*IDXW-1:0]    rnd_q, rnd_d;
  logic [N*IDXW-1:0]    match_q, match_d;
  logic [SUMW-1:0]      weight_q, weight_d;
  logic                 valid_q, valid_d;
  logic                 accept;
  logic [N*IDXW-1:0]    rnd_perm;
  logic [N*IDXW-1:0]    cand   [NC];
  logic [SUMW-1:0]      cand_w [NC];
  logic [CIW-1:0]       best_sel;

  assign accept = slot_i && (state_q == ST_IDLE);

  mwl_rand_perm #(.N(N), .IDXW(IDXW), .SEED(SEED)) i_rand (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv_i  (accept),
    .perm_o (rnd_perm)
  );

  // candidate 0: stored matching; last: random permutation
  assign cand[0]    = match_q;
  assign cand[NC-1] = rnd_q;

  for (genvar k = 0; k < NNB; k++) begin : g_nb
    localparam int KA = k;
    localparam int KB = (k + 1) % N;
    logic [N*IDXW-1:0] nb_perm;
    always_comb begin
      nb_perm = match_q;
      nb_perm[KA*IDXW +: IDXW] = match_q[KB*IDXW +: IDXW];
      nb_perm[KB*IDXW +: IDXW] = match_q[KA*IDXW +: IDXW];
    end
    assign cand[k+1] = nb_perm;
  end

  for (genvar c = 0; c < NC; c++) begin : g_wt
    mwl_weight #(.N(N), .IDXW(IDXW), .WBITS(WBITS), .SUMW(SUMW)) i_wt (
      .perm_i   (cand[c]),
      .qlen_i   (qlen_q),
      .weight_o (cand_w[c])
    );
  end

  // strict comparison: earlier candidate wins on ties
  always_comb begin
    best_sel = '0;
    for (int c = 1; c < NC; c++) begin
      if (cand_w[c] > cand_w[best_sel]) begin
        best_sel = CIW'(c);
      end
    end
  end

  always_comb begin
    state_d  = state_q;
    qlen_d   = qlen_q;
    rnd_d    = rnd_q;
    match_d  = match_q;
    weight_d = weight_q;
    valid_d  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          qlen_d  = qlen_i;
          rnd_d   = rnd_perm;
          state_d = ST_EVAL;
        end
      end
      ST_EVAL: begin
        match_d  = cand[best_sel];
        weight_d = cand_w[best_sel];
        valid_d  = 1'b1;
        state_d  = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      qlen_q   <= '0;
      valid_q  <= 1'b0;
      weight_q <= '0;
      for (int i = 0; i < N; i++) begin
        rnd_q[i*IDXW +: IDXW]   <= IDXW'(i);
        match_q[i*IDXW +: IDXW] <= IDXW'(i);
      end
    end else begin
      state_q  <= state_d;
      qlen_q   <= qlen_d;
      rnd_q    <= rnd_d;
      match_q  <= match_d;
      weight_q <= weight_d;
      valid_q  <= valid_d;
    end
  end

  assign match_o  = match_q;
  assign weight_o = weight_q;
  assign valid_o  = valid_q;

  // assertions
  logic [N-1:0] seen;
  always_comb begin
    seen = '0;
    for (int i = 0; i < N; i++) begin
      seen[match_q[i*IDXW +: IDXW]] = 1'b1;
    end
  end

  a_r4_match_is_perm: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(seen) == N);

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);

  a_r2_eval_then_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_EVAL) |=> valid_q);

  a_r5_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_EVAL) |=> (weight_q >= $past(cand_w[0])));

  for (genvar k = 0; k < NNB; k++) begin : g_nb_chk
    a_r6_beats_neighbour: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_EVAL) |=> (weight_q >= $past(cand_w[k+1])));
  end

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> ($stable(match_q) && $stable(weight_q)));
endmodule

// File: tb/test_mwl_match_learner.sv
module test_mwl_match_learner;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int WBITS = 4;
  localparam int IDXW = 2;
  localparam int SUMW = 6;
  localparam int NNB = N - 1;

  typedef int perm_t [N];
  typedef int mat_t [N][N];

  logic                 clk;
  logic                 rst_n;
  logic                 slot_i;
  logic [N*N*WBITS-1:0] qlen_i;
  logic [N*IDXW-1:0]    match_o;
  logic [SUMW-1:0]      weight_o;
  logic                 valid_o;

  int    n_tests = 0;
  int    n_fail  = 0;
  int    rnd_wins = 0;
  perm_t prev;

  mwl_match_learner #(.N(N), .WBITS(WBITS)) i_mwl_match_learner (
    .clk      (clk),
    .rst_n    (rst_n),
    .slot_i   (slot_i),
    .qlen_i   (qlen_i),
    .match_o  (match_o),
    .weight_o (weight_o),
    .valid_o  (valid_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    n_fail++;
    n_tests++;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int wt(input perm_t p, input mat_t m);
    int s = 0;
    for (int i = 0; i < N; i++) s += m[i][p[i]];
    return s;
  endfunction

  function automatic perm_t dut_perm();
    perm_t p;
    for (int i = 0; i < N; i++) p[i] = int'(match_o[i*IDXW +: IDXW]);
    return p;
  endfunction

  function automatic int perm_code(input perm_t p);
    int c = 0;
    for (int i = 0; i < N; i++) c = c * 10 + p[i];
    return c;
  endfunction

  function automatic logic [N*N*WBITS-1:0] pack(input mat_t m);
    logic [N*N*WBITS-1:0] v;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        v[(i*N+j)*WBITS +: WBITS] = WBITS'(m[i][j]);
    return v;
  endfunction

  // one slot; disturb: alter qlen_i after capture; hold2: keep strobe high into evaluation
  task automatic run_slot(input mat_t m, input bit disturb, input bit hold2);
    perm_t got;
    perm_t cands [NNB+1];
    int    best_w;
    int    best_i;
    int    used;
    @(negedge clk);
    qlen_i = pack(m);
    slot_i = 1'b1;
    @(negedge clk);
    slot_i = hold2;
    chk(valid_o == 1'b0, "R2 valid low after accept edge", int'(valid_o), 0);
    if (disturb) qlen_i = ~qlen_i;
    @(negedge clk);
    slot_i = 1'b0;
    chk(valid_o == 1'b1, "R2 valid after second edge", int'(valid_o), 1);
    got = dut_perm();
    used = 0;
    for (int i = 0; i < N; i++) used |= (1 << got[i]);
    chk(used == (1 << N) - 1, "R4 permutation", used, (1 << N) - 1);
    chk(int'(weight_o) == wt(got, m), "R3/R9 weight of reported match", int'(weight_o), wt(got, m));
    cands[0] = prev;
    for (int k = 0; k < NNB; k++) begin
      int a = k;
      int b = (k + 1) % N;
      cands[k+1] = prev;
      cands[k+1][a] = prev[b];
      cands[k+1][b] = prev[a];
    end
    best_w = wt(cands[0], m);
    best_i = 0;
    for (int c = 1; c <= NNB; c++) begin
      if (wt(cands[c], m) > best_w) begin
        best_w = wt(cands[c], m);
        best_i = c;
      end
    end
    chk(int'(weight_o) >= wt(prev, m), "R5 no drop", int'(weight_o), wt(prev, m));
    chk(int'(weight_o) >= best_w, "R6 beats neighbours", int'(weight_o), best_w);
    if (int'(weight_o) == best_w) begin
      chk(perm_code(got) == perm_code(cands[best_i]), "R7 tie preference",
          perm_code(got), perm_code(cands[best_i]));
    end else if (int'(weight_o) > best_w) begin
      rnd_wins++;
    end
    @(negedge clk);
    chk(valid_o == 1'b0, "R2/R9 single pulse", int'(valid_o), 0);
    // R10: hold while idle even with new input values
    qlen_i = ~qlen_i;
    @(negedge clk);
    chk(perm_code(dut_perm()) == perm_code(got) && valid_o == 1'b0, "R10 hold",
        perm_code(dut_perm()), perm_code(got));
    prev = got;
  endtask

  initial begin
    mat_t m;
    rst_n  = 1'b0;
    slot_i = 1'b0;
    qlen_i = '0;
    for (int i = 0; i < N; i++) prev[i] = i;
    #(CLK_PERIOD * 3);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(perm_code(dut_perm()) == perm_code(prev), "R1 identity after reset",
        perm_code(dut_perm()), perm_code(prev));
    chk(weight_o == '0, "R1 weight zero", int'(weight_o), 0);
    chk(valid_o == 1'b0, "R1 valid low", int'(valid_o), 0);

    // R7: all-zero and all-equal matrices keep the stored matching
    for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) m[i][j] = 0;
    run_slot(m, 1'b0, 1'b0);
    chk(perm_code(prev) == 123, "R7 zero matrix keeps identity", perm_code(prev), 123);
    for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) m[i][j] = 5;
    run_slot(m, 1'b0, 1'b0);
    chk(perm_code(prev) == 123, "R7 equal matrix keeps identity", perm_code(prev), 123);
    chk(int'(weight_o) == 20, "R3 equal matrix weight", int'(weight_o), 20);

    // R6: only edges (1,2) and (2,1) loaded: neighbour 1 must be reached
    for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) m[i][j] = 0;
    m[1][2] = 15;
    m[2][1] = 15;
    run_slot(m, 1'b1, 1'b1);
    chk(int'(weight_o) == 30, "R6 neighbour swap found", int'(weight_o), 30);

    // sweep: diagonal, anti-diagonal and random matrices
    for (int s = 0; s < 300; s++) begin
      for (int i = 0; i < N; i++) begin
        for (int j = 0; j < N; j++) begin
          case (s % 4)
            0: m[i][j] = (i == j) ? 15 : int'($urandom_range(0, 3));
            1: m[i][j] = (i + j == N - 1) ? 14 : int'($urandom_range(0, 4));
            default: m[i][j] = int'($urandom_range(0, 15));
          endcase
        end
      end
      run_slot(m, (s % 3) == 0, (s % 5) == 0);
    end
    chk(rnd_wins > 0, "R8 random candidate wins sometimes", rnd_wins, 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule